// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block is the digital control that takes a regulator's DAC target code from zero up to its working level. It waits until every enable and power-on qualifier is true and the configuration load has finished. It then counts a fixed settling delay and ramps the code one step at a time to a boot level. It holds that level until a voltage command arrives, and then ramps to the commanded level at a programmable slew rate. One code step is 5 mV.

A nonzero command that arrives during the boot ramp turns the ramp around at once. A command that arrives during the second ramp retargets it from the present code. Code zero means "off": it forces the output to zero and latches a shutdown flag. If any qualifier drops, the sequencer returns to idle with a code of zero.

The step interval comes from a clock prescaler. With rate setting 0 there is one step every `CLK_PER_US` clocks, which is 5 mV/µs. Each increment of the rate setting doubles the interval. The boot ramp always uses rate 0.

Top module: `vr_softstart_seq`

## Requirements
- R1: During and right after reset, `dac_code` is 0 and `ramp_active`, `vr_ready` and `shutdown` are all low.
- R2: While any bit of `qual_in` is low or `cfg_done` is low, the sequencer stays idle with `dac_code` at 0 and all flags low.
- R3: Once all qualifiers and `cfg_done` are high, `DELAY_US*CLK_PER_US` clocks pass before `ramp_active` rises.
- R4: The boot ramp raises `dac_code` by one step every `CLK_PER_US` clocks until it equals `boot_code`. It then holds there with `ramp_active` and `vr_ready` low.
- R5: A command with nonzero `cmd_code`, received in hold, starts a ramp to that code with one step every `CLK_PER_US << slew_sel` clocks.
- R6: A nonzero command received during the boot ramp reverses or redirects the ramp straight toward the new code, without first reaching boot.
- R7: A command with `cmd_code` equal to 0 (the off code) sets `shutdown` and forces `dac_code` to 0 on the next clock. Later commands have no effect until the qualifiers drop.
- R8: `vr_ready` is high only when the second ramp has reached the commanded code and no ramp is active.
- R9: A low bit on `qual_in` sends the sequencer to idle on the next clock, with `dac_code` 0 and all flags low.
- R10: A nonzero command received during the second ramp retargets it from the present code, with no return to zero.
- R11: Apart from a forced return to 0, `dac_code` changes by exactly one step at a time.
- R12: Commands received while idle or in the fixed delay are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_in | input | QUAL_N | Enable and power-on qualifiers; all must be high |
| cfg_done | input | 1 | Configuration load finished |
| boot_code | input | CODE_W | Boot level in 5 mV steps |
| slew_sel | input | RATE_W | Second-ramp rate; the interval is doubled per count |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | CODE_W | Commanded level; 0 means off |
| dac_code | output | CODE_W | DAC target code in 5 mV steps |
| ramp_active | output | 1 | A ramp is in progress |
| vr_ready | output | 1 | Commanded level reached |
| shutdown | output | 1 | Off code received |

## Verification
The assertions assume that `boot_code` is stable from the moment sequencing starts until the boot ramp ends. They also assume that `cmd_code` and `slew_sel` are valid during the cycle in which `cmd_valid` is high, and that `CLK_PER_US` is at least 2. The stimulus changes `boot_code` only while the block is idle. It drives every command as a single-cycle strobe with its data and rate applied together, and it keeps the default prescaler value.

// File: rtl/vr_ss_pkg.sv
package vr_ss_pkg;

    typedef enum logic [2:0] {
        SS_IDLE      = 3'd0,
        SS_DELAY     = 3'd1,
        SS_RAMP_BOOT = 3'd2,
        SS_HOLD      = 3'd3,
        SS_RAMP_TGT  = 3'd4,
        SS_READY     = 3'd5,
        SS_SHUT      = 3'd6
    } ss_state_e;

    function automatic logic ss_is_ramp(input ss_state_e s);
        return (s == SS_RAMP_BOOT) || (s == SS_RAMP_TGT);
    endfunction

    // States in which a voltage command is accepted
    function automatic logic ss_takes_cmd(input ss_state_e s);
        return (s == SS_RAMP_BOOT) || (s == SS_HOLD) ||
               (s == SS_RAMP_TGT)  || (s == SS_READY);
    endfunction

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
    parameter int CLK_PER_US = 4,
    parameter int RATE_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              tick
);
    localparam int MAX_IV = CLK_PER_US << ((1 << RATE_W) - 1);
    localparam int CNT_W  = $clog2(MAX_IV + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = (CNT_W'(CLK_PER_US) << rate_sel) - CNT_W'(1);
        tick = run && !restart && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) cnt <= '0;
        else                                cnt <= cnt + CNT_W'(1);
    end

    // R5: a restart always opens a full interval before the next step
    p_restart_gap_r5: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

endmodule

// File: rtl/ss_code_stepper.sv
module ss_code_stepper #(
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              tick,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] code,
    output logic              at_target
);
    assign at_target = (code == target);

    always_ff @(posedge clk) begin
        if (rst || clear)
            code <= '0;
        else if (tick && !at_target)
            code <= (code < target) ? code + CODE_W'(1) : code - CODE_W'(1);
    end

    p_unit_step_r11: assert property (@(posedge clk) disable iff (rst)
        (!clear && tick && !at_target) |=>
            ((code == $past(code) + CODE_W'(1)) || (code == $past(code) - CODE_W'(1))));

    p_hold_still_r4: assert property (@(posedge clk) disable iff (rst)
        (!clear && !tick) |=> $stable(code));

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
    import vr_ss_pkg::*;
#(
    parameter int CODE_W     = 9,
    parameter int RATE_W     = 2,
    parameter int QUAL_N     = 3,
    parameter int CLK_PER_US = 4,
    parameter int DELAY_US   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [QUAL_N-1:0] qual_in,
    input  logic              cfg_done,
    input  logic [CODE_W-1:0] boot_code,
    input  logic [RATE_W-1:0] slew_sel,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic [CODE_W-1:0] dac_code,
    output logic              ramp_active,
    output logic              vr_ready,
    output logic              shutdown
);
    localparam int DLY_CYC = DELAY_US * CLK_PER_US;
    localparam int DLY_W   = $clog2(DLY_CYC + 1);

    ss_state_e          state_q, state_n;
    logic [DLY_W-1:0]   dly_cnt;
    logic [CODE_W-1:0]  boot_q, tgt_q, step_tgt;
    logic [RATE_W-1:0]  rate_q, rate_use;
    logic               qual_ok, cmd_take, cmd_off, tick, at_target, clr;

    assign qual_ok  = &qual_in;
    assign cmd_take = cmd_valid && qual_ok && ss_takes_cmd(state_q);
    assign cmd_off  = (cmd_code == '0);

    always_comb begin
        state_n = state_q;
        if (!qual_ok) begin
            state_n = SS_IDLE;
        end else if (cmd_take) begin
            state_n = cmd_off ? SS_SHUT : SS_RAMP_TGT;
        end else begin
            case (state_q)
                SS_IDLE:      if (cfg_done) state_n = SS_DELAY;
                SS_DELAY:     if (dly_cnt == DLY_W'(DLY_CYC - 1)) state_n = SS_RAMP_BOOT;
                SS_RAMP_BOOT: if (at_target) state_n = SS_HOLD;
                SS_RAMP_TGT:  if (at_target) state_n = SS_READY;
                default:      state_n = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SS_IDLE;
            dly_cnt <= '0;
            boot_q  <= '0;
            tgt_q   <= '0;
            rate_q  <= '0;
        end else begin
            state_q <= state_n;
            dly_cnt <= (state_q == SS_DELAY) ? dly_cnt + DLY_W'(1) : '0;
            if (state_q == SS_IDLE) boot_q <= boot_code;
            if (cmd_take && !cmd_off) begin
                tgt_q  <= cmd_code;
                rate_q <= slew_sel;
            end
        end
    end

    always_comb begin
        step_tgt = (state_q == SS_RAMP_TGT || state_q == SS_READY) ? tgt_q : boot_q;
        rate_use = (state_q == SS_RAMP_TGT) ? rate_q : '0;
        clr      = (state_n == SS_IDLE) || (state_n == SS_SHUT);
    end

    ss_step_timer #(.CLK_PER_US(CLK_PER_US), .RATE_W(RATE_W)) u_timer (
        .clk(clk), .rst(rst), .run(ss_is_ramp(state_q)), .restart(cmd_take),
        .rate_sel(rate_use), .tick(tick)
    );

    ss_code_stepper #(.CODE_W(CODE_W)) u_step (
        .clk(clk), .rst(rst), .clear(clr), .tick(tick), .target(step_tgt),
        .code(dac_code), .at_target(at_target)
    );

    assign ramp_active = ss_is_ramp(state_q);
    assign vr_ready    = (state_q == SS_READY);
    assign shutdown    = (state_q == SS_SHUT);

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ramp_active, vr_ready, shutdown}));

    p_ready_code_r8: assert property (@(posedge clk) disable iff (rst)
        vr_ready |-> (dac_code == tgt_q));

    p_shut_zero_r7: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (dac_code == '0));

    p_drop_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !qual_ok |=> (dac_code == '0 && !ramp_active && !vr_ready && !shutdown));

    p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_IDLE && !(qual_ok && cfg_done)) |=> (state_q == SS_IDLE));

    p_delay_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_DELAY) |-> (dac_code == '0));

endmodule

// File: tb/tb_vr_softstart_seq.sv
module tb_vr_softstart_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W = 9, RATE_W = 2, QUAL_N = 3, CPU = 4, DLY_US = 20;
    localparam int DLY = DLY_US * CPU;

    logic              clk = 0, rst = 1;
    logic [QUAL_N-1:0] qual_in = '0;
    logic              cfg_done = 0, cmd_valid = 0;
    logic [CODE_W-1:0] boot_code = '0, cmd_code = '0;
    logic [RATE_W-1:0] slew_sel = '0;
    logic [CODE_W-1:0] dac_code;
    logic              ramp_active, vr_ready, shutdown;

    int n_chk = 0, n_fail = 0, cyc = 0, step_bad = 0;
    logic [CODE_W-1:0] prev_code = '0;

    vr_softstart_seq #(.CODE_W(CODE_W), .RATE_W(RATE_W), .QUAL_N(QUAL_N),
                       .CLK_PER_US(CPU), .DELAY_US(DLY_US)) dut (
        .clk(clk), .rst(rst), .qual_in(qual_in), .cfg_done(cfg_done),
        .boot_code(boot_code), .slew_sel(slew_sel), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .dac_code(dac_code), .ramp_active(ramp_active),
        .vr_ready(vr_ready), .shutdown(shutdown));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // R11 monitor: each change is one step, or a forced drop to zero
    always @(negedge clk) begin
        if (!rst && dac_code != prev_code && dac_code != '0 &&
            dac_code != prev_code + 1 && dac_code != prev_code - 1)
            step_bad = step_bad + 1;
        prev_code = dac_code;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic send_cmd(input int code, input int sel);
        cmd_valid = 1; cmd_code = CODE_W'(code); slew_sel = RATE_W'(sel);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic ramp_len(output int n);
        n = 0;
        while (ramp_active && n < 20000) begin n++; @(negedge clk); end
    endtask

    task automatic to_idle();
        qual_in = '0; cfg_done = 0;
        repeat (2) @(negedge clk);
        qual_in = '1;
    endtask

    // bring up to hold at boot b; returns delay and boot-ramp lengths
    task automatic bring_up(input int b, output int d, output int n);
        boot_code = CODE_W'(b);
        @(negedge clk);
        cfg_done = 1;
        d = 0;
        while (!ramp_active && d < 5000) begin @(negedge clk); d++; end
        ramp_len(n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(dac_code == 0 && !ramp_active && !vr_ready && !shutdown, "R1 reset", dac_code, 0);
        rst = 0;
        @(negedge clk);
        chk(dac_code == 0 && !ramp_active && !vr_ready && !shutdown, "R1 after reset", dac_code, 0);
    endtask

    task automatic t_no_start();
        qual_in = 3'b101; cfg_done = 1; boot_code = 50;
        repeat (200) @(negedge clk);
        chk(dac_code == 0 && !ramp_active, "R2 qualifier low", dac_code, 0);
        qual_in = '1; cfg_done = 0;
        repeat (200) @(negedge clk);
        chk(dac_code == 0 && !ramp_active, "R2 cfg not done", dac_code, 0);
    endtask

    task automatic t_boot_and_second();
        int d, n;
        bring_up(220, d, n);
        chk(d >= DLY && d <= DLY + 2, "R3 delay", d, DLY + 1);
        chk(n >= 220*CPU && n <= 220*CPU + 2, "R4 boot ramp length", n, 220*CPU + 1);
        repeat (50) @(negedge clk);
        chk(dac_code == 220 && !ramp_active && !vr_ready, "R4 hold at boot", dac_code, 220);
        send_cmd(300, 1);
        ramp_len(n);
        chk(n >= 80*CPU*2 && n <= 80*CPU*2 + 2, "R5 second ramp slew 1", n, 80*CPU*2 + 1);
        @(negedge clk);
        chk(dac_code == 300 && vr_ready && !ramp_active, "R8 ready at target", dac_code, 300);
        qual_in = 3'b110;
        @(negedge clk);
        chk(dac_code == 0 && !vr_ready && !ramp_active && !shutdown, "R9 drop to idle", dac_code, 0);
        to_idle();
    endtask

    task automatic t_ignore_early();
        int d, n;
        boot_code = 40;
        @(negedge clk);
        cfg_done = 1;
        repeat (10) @(negedge clk);
        send_cmd(120, 0);
        d = 0;
        while (!ramp_active && d < 5000) begin @(negedge clk); d++; end
        ramp_len(n);
        repeat (5) @(negedge clk);
        chk(dac_code == 40 && !vr_ready, "R12 delay command ignored", dac_code, 40);
        to_idle();
    endtask

    task automatic t_turnaround();
        int n, mx;
        boot_code = 220;
        @(negedge clk);
        cfg_done = 1;
        while (dac_code < 50) @(negedge clk);
        send_cmd(30, 0);
        mx = dac_code; n = 0;
        while (!vr_ready && n < 5000) begin
            if (dac_code > mx) mx = dac_code;
            @(negedge clk); n++;
        end
        chk(mx <= 51, "R6 no climb after command", mx, 51);
        chk(dac_code == 30 && vr_ready, "R6 reached new code", dac_code, 30);
        to_idle();
    endtask

    task automatic t_retarget();
        int d, n, mn;
        bring_up(100, d, n);
        send_cmd(300, 0);
        while (dac_code < 200) @(negedge clk);
        send_cmd(150, 0);
        mn = dac_code; n = 0;
        while (!vr_ready && n < 5000) begin
            if (dac_code < mn) mn = dac_code;
            @(negedge clk); n++;
        end
        chk(mn >= 150, "R10 no restart from zero", mn, 150);
        chk(dac_code == 150 && vr_ready, "R10 retarget reached", dac_code, 150);
        to_idle();
    endtask

    task automatic t_off();
        int d, n;
        bring_up(60, d, n);
        send_cmd(0, 0);
        chk(shutdown && dac_code == 0 && !ramp_active, "R7 off code", dac_code, 0);
        send_cmd(200, 0);
        repeat (20) @(negedge clk);
        chk(shutdown && dac_code == 0, "R7 command after off ignored", dac_code, 0);
        qual_in = 3'b011;
        @(negedge clk);
        chk(!shutdown && dac_code == 0, "R9 drop clears shutdown", shutdown, 0);
        to_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_no_start();
        to_idle();
        t_boot_and_second();
        t_ignore_early();
        t_turnaround();
        t_retarget();
        t_off();
        chk(step_bad == 0, "R11 single steps", step_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule